// File: doc/BRIEF.md
# Conversion Sequence and Mode Controller

This block times the per-sample work of a combined analog-to-digital and digital-to-analog converter. It takes two slow clocks: a frame-sync clock whose period is one sample, and a convert clock whose rising edge lines up with the frame-sync rising edge. A fast system clock samples both through synchronizer chains and turns their transitions into single-cycle edge events. The block counts the convert-clock rising edges in each frame and works out the operating mode from that count. It then fires one-cycle strobes at fixed convert-clock positions inside the frame: input sample, conversion start, transmit latch update, receive latch load and analog output update.

A count of 32 per frame runs both directions. A count of 24 runs the analog-to-digital direction only. A count of 8 runs the digital-to-analog direction only. Any other count, or two consecutive frames that disagree, leaves the block idle. A low power input halts everything and clears what the block has learned. When the power input returns high, the mode has to be measured again from scratch.

Top module: `conv_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no clock activity, `mode_o` is 00 and all five strobes are 0.
- R2: A frame is the span between two successive frame-sync rising edges, and its count is the number of convert-clock rising edges in it, the aligned edge included. At the third frame-sync rising edge after reset, two complete frames have been measured. If both counted 32, `mode_o` becomes 01 (full), and strobes are issued from that frame onward. Before that edge `mode_o` is 00.
- R3: Two consecutive frame counts of 24 give `mode_o` = 10 (conversion in only). Two consecutive counts of 8 give `mode_o` = 11 (conversion out only).
- R4: Any frame count other than 8, 24 or 32, or two consecutive counts that differ, gives `mode_o` = 00. While `mode_o` is 00, every strobe stays 0.
- R5: `sample_o` pulses on convert-clock rising edge index 0 of the frame, the one aligned with frame sync. It fires only in modes 01 and 10.
- R6: `adc_start_o` pulses on the first convert-clock falling edge of the frame (falling index 0). It fires only in modes 01 and 10.
- R7: `tx_latch_o` pulses on rising index R-1, where R is the ratio of the current mode. That edge comes one and a half convert periods before the next frame's conversion start. It fires only in modes 01 and 10.
- R8: `rx_latch_o` pulses on falling index R-1, the last falling edge before the next frame sync. `aout_upd_o` pulses on rising index R-1. Both fire only in modes 01 and 11.
- R9: While `pwr_on` is low, all strobes are 0 and `mode_o` is 00 from the next clock onward, and the mode history is cleared. After `pwr_on` returns high, strobes resume only once two complete frames have again been measured.
- R10: A strobe, or a change of `mode_o`, appears three system clock edges after the input transition that causes it. Two of those edges are synchronizer stages and one is the output register.
- R11: `mode_o` changes only at a frame-sync rising edge or through power-down. The mode decided at a frame-sync edge governs every strobe of the frame that edge starts, its index-0 strobes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | High for normal operation; low halts and clears the block |
| fsync_in | input | 1 | Frame-sync clock, one period per sample |
| cclk_in | input | 1 | Convert clock, rising edges aligned with frame sync |
| mode_o | output | 2 | 00 undetermined, 01 full, 10 conversion in only, 11 conversion out only |
| sample_o | output | 1 | Input sample strobe |
| adc_start_o | output | 1 | Analog-to-digital conversion start strobe |
| tx_latch_o | output | 1 | Transmit latch update strobe |
| rx_latch_o | output | 1 | Receive latch load strobe |
| aout_upd_o | output | 1 | Analog output update strobe |

## Verification
The bench builds the block with its default ratios 32, 24 and 8, two synchronizer stages and a counter wide enough to reach 127. At those values every frame-position corner can be reached within a few thousand cycles. The bench drives the convert clock at half-periods of two and three system cycles. It sweeps frame lengths from 4 to 34 convert cycles, so every unrecognized ratio on both sides of the three legal ones is covered, along with ratio changes in both directions and alternating frame lengths. Power-down is entered and left with both clocks running, and the re-measurement after release is checked.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

   typedef enum logic [1:0] {
      MODE_NONE = 2'b00,
      MODE_FULL = 2'b01,
      MODE_ADC  = 2'b10,
      MODE_DAC  = 2'b11
   } cseq_mode_e;

   typedef struct packed {
      logic smp;
      logic adc;
      logic txl;
      logic rxl;
      logic aout;
   } cseq_strb_t;

endpackage

// File: rtl/cseq_sync.sv
module cseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl_o,
   output logic dly_o
);
   localparam int LAST = STAGES;

   logic [LAST:0] sh;

   initial begin
      AST_SYNC_DEPTH: assert (STAGES >= 2) else $error("sync depth below 2");
   end

   generate
      for (genvar i = 0; i <= LAST; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
            end
         end
      end
   endgenerate

   assign lvl_o = sh[LAST-1];
   assign dly_o = sh[LAST];
endmodule

// File: rtl/cseq_frame_meter.sv
module cseq_frame_meter
   import cseq_pkg::*;
#(
   parameter int FULL_R = 32,
   parameter int ADC_R  = 24,
   parameter int DAC_R  = 8,
   parameter int CNT_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_on,
   input  logic             cc_rise,
   input  logic             cc_fall,
   input  logic             fs_rise,
   output cseq_mode_e       mode_q,
   output cseq_mode_e       mode_nxt,
   output logic [CNT_W-1:0] rise_idx,
   output logic [CNT_W-1:0] fall_idx
);
   logic [CNT_W-1:0] rise_cnt, fall_cnt;
   logic             seen_q, prev_ok_q;
   cseq_mode_e       prev_cand_q, cand;

   function automatic cseq_mode_e classify(input logic [CNT_W-1:0] c);
      if (c == CNT_W'(FULL_R))     return MODE_FULL;
      else if (c == CNT_W'(ADC_R)) return MODE_ADC;
      else if (c == CNT_W'(DAC_R)) return MODE_DAC;
      else                         return MODE_NONE;
   endfunction

   always_comb begin
      cand     = classify(rise_cnt);
      rise_idx = fs_rise ? '0 : rise_cnt;
      fall_idx = fs_rise ? '0 : fall_cnt;
      mode_nxt = mode_q;
      if (!pwr_on)
         mode_nxt = MODE_NONE;
      else if (fs_rise && seen_q)
         mode_nxt = (prev_ok_q && cand == prev_cand_q) ? cand : MODE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt    <= '0;
         fall_cnt    <= '0;
         seen_q      <= 1'b0;
         prev_ok_q   <= 1'b0;
         prev_cand_q <= MODE_NONE;
         mode_q      <= MODE_NONE;
      end else if (!pwr_on) begin
         rise_cnt    <= '0;
         fall_cnt    <= '0;
         seen_q      <= 1'b0;
         prev_ok_q   <= 1'b0;
         prev_cand_q <= MODE_NONE;
         mode_q      <= MODE_NONE;
      end else begin
         mode_q <= mode_nxt;
         if (fs_rise) begin
            rise_cnt <= {{(CNT_W-1){1'b0}}, cc_rise};
            fall_cnt <= {{(CNT_W-1){1'b0}}, cc_fall};
            seen_q   <= 1'b1;
            if (seen_q) begin
               prev_ok_q   <= 1'b1;
               prev_cand_q <= cand;
            end
         end else begin
            if (cc_rise && rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
            if (cc_fall && fall_cnt != '1) fall_cnt <= fall_cnt + 1'b1;
         end
      end
   end

   AST_MODE_ONLY_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && !fs_rise) |=> $stable(mode_q)); // R11

   AST_TWO_FRAMES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && fs_rise && !prev_ok_q) |=> (mode_q == MODE_NONE)); // R2
endmodule

// File: rtl/cseq_strobe_gen.sv
module cseq_strobe_gen
   import cseq_pkg::*;
#(
   parameter int FULL_R = 32,
   parameter int ADC_R  = 24,
   parameter int DAC_R  = 8,
   parameter int CNT_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_on,
   input  logic             cc_rise,
   input  logic             cc_fall,
   input  cseq_mode_e       mode_nxt,
   input  logic [CNT_W-1:0] rise_idx,
   input  logic [CNT_W-1:0] fall_idx,
   output cseq_strb_t       strb_o
);
   cseq_strb_t       strb_d;
   logic             has_ad, has_da;
   logic [CNT_W-1:0] last_idx;

   always_comb begin
      has_ad   = (mode_nxt == MODE_FULL) || (mode_nxt == MODE_ADC);
      has_da   = (mode_nxt == MODE_FULL) || (mode_nxt == MODE_DAC);
      case (mode_nxt)
         MODE_FULL: last_idx = CNT_W'(FULL_R - 1);
         MODE_ADC:  last_idx = CNT_W'(ADC_R - 1);
         MODE_DAC:  last_idx = CNT_W'(DAC_R - 1);
         default:   last_idx = '1;
      endcase
      strb_d.smp  = has_ad && cc_rise && (rise_idx == '0);
      strb_d.txl  = has_ad && cc_rise && (rise_idx == last_idx);
      strb_d.aout = has_da && cc_rise && (rise_idx == last_idx);
      strb_d.adc  = has_ad && cc_fall && (fall_idx == '0);
      strb_d.rxl  = has_da && cc_fall && (fall_idx == last_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       strb_o <= '0;
      else if (!pwr_on) strb_o <= '0;
      else              strb_o <= strb_d;
   end

   AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> (strb_o == '0)); // R9
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
   import cseq_pkg::*;
#(
   parameter int FULL_R      = 32,
   parameter int ADC_R       = 24,
   parameter int DAC_R       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_on,
   input  logic       fsync_in,
   input  logic       cclk_in,
   output logic [1:0] mode_o,
   output logic       sample_o,
   output logic       adc_start_o,
   output logic       tx_latch_o,
   output logic       rx_latch_o,
   output logic       aout_upd_o
);
   localparam int CNT_W = $clog2(FULL_R) + 2;

   initial begin
      AST_RATIO_ORDER: assert (FULL_R > ADC_R && ADC_R > DAC_R && DAC_R >= 2)
         else $error("ratios must be strictly ordered");
   end

   logic fs_lvl, fs_dly, cc_lvl, cc_dly;
   logic fs_rise, cc_rise, cc_fall;
   cseq_mode_e       mode_q, mode_nxt;
   logic [CNT_W-1:0] rise_idx, fall_idx;
   cseq_strb_t       strb;

   cseq_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
      .clk(clk), .rst_n(rst_n), .din(fsync_in), .lvl_o(fs_lvl), .dly_o(fs_dly));
   cseq_sync #(.STAGES(SYNC_STAGES)) u_cc_sync (
      .clk(clk), .rst_n(rst_n), .din(cclk_in), .lvl_o(cc_lvl), .dly_o(cc_dly));

   assign fs_rise = fs_lvl & ~fs_dly;
   assign cc_rise = cc_lvl & ~cc_dly;
   assign cc_fall = ~cc_lvl & cc_dly;

   cseq_frame_meter #(.FULL_R(FULL_R), .ADC_R(ADC_R), .DAC_R(DAC_R), .CNT_W(CNT_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
      .cc_rise(cc_rise), .cc_fall(cc_fall), .fs_rise(fs_rise),
      .mode_q(mode_q), .mode_nxt(mode_nxt), .rise_idx(rise_idx), .fall_idx(fall_idx));

   cseq_strobe_gen #(.FULL_R(FULL_R), .ADC_R(ADC_R), .DAC_R(DAC_R), .CNT_W(CNT_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
      .cc_rise(cc_rise), .cc_fall(cc_fall), .mode_nxt(mode_nxt),
      .rise_idx(rise_idx), .fall_idx(fall_idx), .strb_o(strb));

   assign mode_o      = mode_q;
   assign sample_o    = strb.smp;
   assign adc_start_o = strb.adc;
   assign tx_latch_o  = strb.txl;
   assign rx_latch_o  = strb.rxl;
   assign aout_upd_o  = strb.aout;

   AST_STROBE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o | adc_start_o | tx_latch_o | rx_latch_o | aout_upd_o) |-> (mode_o != 2'b00)); // R4

   AST_OUT_ONLY_NO_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b11) |-> !(sample_o | adc_start_o | tx_latch_o)); // R3

   AST_IN_ONLY_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b10) |-> !(rx_latch_o | aout_upd_o)); // R3
endmodule

// File: tb/conv_seq_ctrl_test.sv
`timescale 1ns/1ps
module conv_seq_ctrl_test;
   logic clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b1, fsync_in = 1'b0, cclk_in = 1'b0;
   logic [1:0] mode_o;
   logic sample_o, adc_start_o, tx_latch_o, rx_latch_o, aout_upd_o;

   conv_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .fsync_in(fsync_in), .cclk_in(cclk_in),
      .mode_o(mode_o), .sample_o(sample_o), .adc_start_o(adc_start_o),
      .tx_latch_o(tx_latch_o), .rx_latch_o(rx_latch_o), .aout_upd_o(aout_upd_o));

   always #4 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   logic [6:0] pipe [3];
   string phase = "R1";
   int m_mode = 0, prev_cand = 0, prev_valid = 0, started = 0, cur_len = 0;
   bit done = 1'b0;

   function automatic int cls(input int n);
      if (n == 32) return 1;
      if (n == 24) return 2;
      if (n == 8)  return 3;
      return 0;
   endfunction

   function automatic int rat(input int m);
      case (m)
         1: return 32;
         2: return 24;
         3: return 8;
         default: return 0;
      endcase
   endfunction

   // R10: each expectation is compared three negedges after it was pushed
   task automatic compare_now();
      logic [6:0] got;
      logic [6:0] d;
      string s;
      got = {mode_o, sample_o, adc_start_o, tx_latch_o, rx_latch_o, aout_upd_o};
      d = got ^ pipe[2];
      n_cmp++;
      if (d != 7'd0) begin
         s = "";
         if (d[6:5] != 2'b00) s = {s, " ", phase};
         if (d[4]) s = {s, " R5"};
         if (d[3]) s = {s, " R6"};
         if (d[2]) s = {s, " R7"};
         if (d[1] | d[0]) s = {s, " R8"};
         n_bad++;
         $display("FAIL%s (R10 timing) got=%b exp=%b at %0t", s, got, pipe[2], $time);
      end
   endtask

   task automatic drive(input logic c, input logic f, input logic [6:0] e);
      @(negedge clk);
      compare_now();
      pipe[2] = pipe[1];
      pipe[1] = pipe[0];
      pipe[0] = e;
      cclk_in = c;
      fsync_in = f;
   endtask

   task automatic idle(input int t);
      repeat (t) drive(1'b0, 1'b0, {2'(m_mode), 5'b0});
   endtask

   task automatic set_pwr(input logic v);
      @(negedge clk);
      compare_now();
      pipe[0] = 7'd0; pipe[1] = 7'd0; pipe[2] = 7'd0;
      pwr_on = v;
      if (!v) begin
         m_mode = 0; prev_cand = 0; prev_valid = 0; started = 0; cur_len = 0;
      end
   endtask

   // frames of n convert cycles, convert half-period h system cycles
   task automatic run(input int n, input int nf, input int h, input string tag);
      int fs_hi, r, cand;
      bit ad, da;
      logic fsv;
      logic [6:0] e;
      phase = tag;
      fs_hi = n / 2;
      for (int f = 0; f < nf; f++) begin
         for (int k = 0; k < n; k++) begin
            if (k == 0 && pwr_on) begin
               if (started != 0) begin
                  cand = cls(cur_len);
                  m_mode = (prev_valid != 0 && cand == prev_cand) ? cand : 0; // R2 R3 R4 R11
                  prev_cand = cand;
                  prev_valid = 1;
               end
               started = 1;
               cur_len = 0;
            end
            r  = rat(m_mode);
            ad = (m_mode == 1) || (m_mode == 2);
            da = (m_mode == 1) || (m_mode == 3);
            fsv = (k < fs_hi);
            e = {2'(m_mode), ad && k == 0, 1'b0, ad && k == r - 1, 1'b0, da && k == r - 1};
            drive(1'b1, fsv, e);
            if (pwr_on) cur_len++;
            repeat (h - 1) drive(1'b1, fsv, {2'(m_mode), 5'b0});
            e = {2'(m_mode), 1'b0, ad && k == 0, 1'b0, da && k == r - 1, 1'b0};
            drive(1'b0, fsv, e);
            repeat (h - 1) drive(1'b0, fsv, {2'(m_mode), 5'b0});
         end
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      pipe[0] = 7'd0; pipe[1] = 7'd0; pipe[2] = 7'd0;
      phase = "R1";
      idle(4);
      rst_n = 1'b1;
      idle(6);
      run(32, 5, 3, "R2");
      run(24, 5, 2, "R3 R11");
      run(8, 5, 3, "R3 R11");
      run(32, 4, 2, "R2 R11");
      for (int n = 4; n <= 34; n++) run(n, 3, 2, "R4");
      for (int i = 0; i < 3; i++) begin
         run(24, 1, 2, "R4");
         run(32, 1, 2, "R4");
      end
      run(32, 4, 3, "R9");
      idle(6);
      set_pwr(1'b0);
      idle(4);
      run(32, 3, 2, "R9");
      idle(6);
      set_pwr(1'b1);
      idle(4);
      run(32, 4, 3, "R9");
      run(8, 4, 2, "R9");
      idle(8);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R10 got=running exp=finished");
         summary();
         $finish;
      end
   end
endmodule